// File: doc/BRIEF.md
# Grouped Multi-Function Interrupt Controller

This block gathers six peripheral event pulses into four sticky source flags and folds those into two interrupt groups. Each group presents one vectored call to a small 8-bit CPU core. Group 0 holds the serial-port source and the frequency-converter counter source, and it calls address 0x14. Group 1 holds the real-time-clock source and the periodic tick source, and it calls address 0x18.

The CPU sees a request with a vector. It answers with an acknowledge. It also drives a stack-full level and a return-from-interrupt strobe. Taking an interrupt clears the global enable and the flag of the group that was served. The source flags stay set after service, so the service routine must clear them through the register port. Software also sets the global enable, the group enables and the source enables through that port.

Register port (2-bit address, 8-bit data):

| Address | Bits | Content |
|---|---|---|
| 0 | bit0 | Global enable |
| 0 | bits1..2 | Group 0 and group 1 enables |
| 1 | bits0..3 | Enables for serial, converter, real-time clock and tick |
| 2 | bits0..3 | Flags for the same four sources, in the same order |
| 2 | bits4..5 | Group 0 and group 1 flags |
| 3 | all | Reads as zero |

Unused bits read as zero.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset, all enables and flags read 0 and `irq_req_o` is low.
- R2: A pulse on a source event sets that source's flag at the next clock edge.
  - `evt_ser_xfer_i` or `evt_ser_match_i` sets flag bit0.
  - `evt_cnv_a_i` or `evt_cnv_b_i` sets bit1.
  - `evt_rtc_i` sets bit2.
  - `evt_tb_i` sets bit3.
- R3: A group flag (address 2, bit4 for group 0, bit5 for group 1) sets one edge after any source of that group has both its flag and its enable set. This holds whatever the group enable is.
- R4: `irq_req_o` is high only when the global enable, a group enable and that group's flag are all set. `irq_vec_o` is then 0x14 for group 0 and 0x18 for group 1.
- R5: While `stack_full_i` is high, `irq_req_o` is low.
- R6: An `irq_ack_i` during a request does three things:
  - It clears the global enable.
  - It clears the flag of the group being served.
  - It leaves all source flags set.

  An acknowledge while no request is raised changes nothing.
- R7: When both groups are eligible, group 0 is served first. Group 1 stays pending and is requested once the global enable is set again.
- R8: A `reti_i` pulse sets the global enable. An acknowledge in the same cycle takes precedence over it.
- R9: A software write to the flag register clears flags. If it falls in the same cycle as a source event, the event wins and the flag ends set.
- R10: A source whose enable is clear still records its flag, but it raises neither its group flag nor a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_ser_xfer_i | input | 1 | Serial byte done pulse |
| evt_ser_match_i | input | 1 | Serial address match pulse |
| evt_cnv_a_i | input | 1 | Converter counter A overflow pulse |
| evt_cnv_b_i | input | 1 | Converter counter B overflow pulse |
| evt_rtc_i | input | 1 | Real-time clock overflow pulse |
| evt_tb_i | input | 1 | Tick overflow pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| irq_req_o | output | 1 | Vectored call request |
| irq_vec_o | output | 8 | Call vector |
| irq_ack_i | input | 1 | CPU takes the call |
| stack_full_i | input | 1 | CPU stack full |
| reti_i | input | 1 | Return-from-interrupt strobe |

## Verification
Two pairs of functions can land in the same cycle:
- A software write that clears the flag register and a source event. The bench drives the tick event in the same cycle as a write of zero to address 2, then reads back bit3 set and bit5 still clear.
- Requests from the two groups. The bench pulses the serial and real-time-clock events together. It expects vector 0x14 first, then 0x18 once the serial flag is cleared and the global enable is set again.

A scoreboard queue holds the expected read data and request/vector values.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int unsigned NUM_GRP     = 2;
  localparam int unsigned SRC_PER_GRP = 2;
  localparam int unsigned NUM_SRC     = NUM_GRP * SRC_PER_GRP;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned ADDR_W      = 2;
  localparam int unsigned VEC_W       = 8;
  localparam int unsigned SEL_W       = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam logic [VEC_W-1:0] VEC_BASE = 8'h14;
  localparam logic [VEC_W-1:0] VEC_STEP = 8'h04;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_SRC_EN = 2'd1,
    REG_FLAGS  = 2'd2,
    REG_RSVD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    // event wins over a software write in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (evt_i[i]) q <= 1'b1;
      else if (wr_i)     q <= wdata_i[i];
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/irq_grp_merge.sv
module irq_grp_merge #(
  parameter int unsigned NG  = 2,
  parameter int unsigned SPG = 2,
  localparam int unsigned NS = NG * SPG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] src_flag_i,
  input  logic [NS-1:0] src_en_i,
  input  logic [NG-1:0] clr_i,
  input  logic          wr_i,
  input  logic [NG-1:0] wdata_i,
  output logic [NG-1:0] grp_flag_o
);
  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic set, q;
    assign set = |(src_flag_i[g*SPG +: SPG] & src_en_i[g*SPG +: SPG]);
    // service clear first, then source merge, then software write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (clr_i[g]) q <= 1'b0;
      else if (set)      q <= 1'b1;
      else if (wr_i)     q <= wdata_i[g];
    end
    assign grp_flag_o[g] = q;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_grp_pkg::*;
#(
  parameter int unsigned NG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NG-1:0]    grp_flag_i,
  input  logic [NG-1:0]    grp_en_i,
  input  logic             stack_full_i,
  input  logic             ack_i,
  input  logic             reti_i,
  input  logic             gie_wr_i,
  input  logic             gie_wdata_i,
  output logic             gie_o,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [NG-1:0]    clr_o
);
  logic [NG-1:0]    elig;
  logic [NG-1:0]    grant;
  logic [SEL_W-1:0] sel;
  logic             gie_q;
  logic             service;

  assign elig = grp_flag_i & grp_en_i & {NG{gie_q}};

  // lowest group index wins
  always_comb begin
    sel   = '0;
    grant = '0;
    for (int i = NG - 1; i >= 0; i--) begin
      if (elig[i]) begin
        sel   = SEL_W'(i);
        grant = NG'(1) << i;
      end
    end
  end

  assign req_o   = (|elig) & ~stack_full_i;
  assign vec_o   = VEC_BASE + VEC_W'(sel) * VEC_STEP;
  assign service = req_o & ack_i;
  assign clr_o   = grant & {NG{service}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gie_q <= 1'b0;
    else if (service)  gie_q <= 1'b0;
    else if (reti_i)   gie_q <= 1'b1;
    else if (gie_wr_i) gie_q <= gie_wdata_i;
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_grp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_ser_xfer_i,
  input  logic              evt_ser_match_i,
  input  logic              evt_cnv_a_i,
  input  logic              evt_cnv_b_i,
  input  logic              evt_rtc_i,
  input  logic              evt_tb_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  input  logic              irq_ack_i,
  input  logic              stack_full_i,
  input  logic              reti_i
);
  logic [NUM_SRC-1:0] src_evt, src_flag, src_en;
  logic [NUM_GRP-1:0] grp_flag, grp_en, grp_clr;
  logic               gie;
  logic               wr_ctrl, wr_src_en, wr_flags;

  assign src_evt = {evt_tb_i, evt_rtc_i,
                    evt_cnv_a_i | evt_cnv_b_i,
                    evt_ser_xfer_i | evt_ser_match_i};

  assign wr_ctrl   = reg_we_i && (reg_addr_i == REG_CTRL);
  assign wr_src_en = reg_we_i && (reg_addr_i == REG_SRC_EN);
  assign wr_flags  = reg_we_i && (reg_addr_i == REG_FLAGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_en <= '0;
      src_en <= '0;
    end else begin
      if (wr_ctrl)   grp_en <= reg_wdata_i[NUM_GRP:1];
      if (wr_src_en) src_en <= reg_wdata_i[NUM_SRC-1:0];
    end
  end

  irq_src_flags #(.N(NUM_SRC)) i_src_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (src_evt),
    .wr_i    (wr_flags),
    .wdata_i (reg_wdata_i[NUM_SRC-1:0]),
    .flag_o  (src_flag)
  );

  irq_grp_merge #(.NG(NUM_GRP), .SPG(SRC_PER_GRP)) i_grp_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_flag_i (src_flag),
    .src_en_i   (src_en),
    .clr_i      (grp_clr),
    .wr_i       (wr_flags),
    .wdata_i    (reg_wdata_i[NUM_SRC+NUM_GRP-1:NUM_SRC]),
    .grp_flag_o (grp_flag)
  );

  irq_dispatch #(.NG(NUM_GRP)) i_dispatch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .grp_flag_i   (grp_flag),
    .grp_en_i     (grp_en),
    .stack_full_i (stack_full_i),
    .ack_i        (irq_ack_i),
    .reti_i       (reti_i),
    .gie_wr_i     (wr_ctrl),
    .gie_wdata_i  (reg_wdata_i[0]),
    .gie_o        (gie),
    .req_o        (irq_req_o),
    .vec_o        (irq_vec_o),
    .clr_o        (grp_clr)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_CTRL: begin
        reg_rdata_o[0]         = gie;
        reg_rdata_o[NUM_GRP:1] = grp_en;
      end
      REG_SRC_EN: reg_rdata_o[NUM_SRC-1:0] = src_en;
      REG_FLAGS: begin
        reg_rdata_o[NUM_SRC-1:0]               = src_flag;
        reg_rdata_o[NUM_SRC+NUM_GRP-1:NUM_SRC] = grp_flag;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

module irq_group_ctrl_chk
  import irq_grp_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               evt_tb_i,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic               irq_req_o,
  input logic [VEC_W-1:0]   irq_vec_o,
  input logic               irq_ack_i,
  input logic               stack_full_i,
  input logic               reti_i,
  input logic               gie_q,
  input logic [NUM_SRC-1:0] src_flag_q,
  input logic [NUM_GRP-1:0] grp_flag_q,
  input logic [NUM_GRP-1:0] grp_en_q
);
  p_full_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_full_i |-> !irq_req_o);

  p_req_needs_gie_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> gie_q);

  p_ack_drops_gie_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_ack_i) |=> !gie_q);

  p_ack_clears_grp0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_ack_i && irq_vec_o == VEC_BASE) |=> !grp_flag_q[0]);

  p_src_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == REG_FLAGS)
      |=> ((src_flag_q & $past(src_flag_q)) == $past(src_flag_q)));

  p_evt_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_tb_i |=> src_flag_q[NUM_SRC-1]);

  p_reti_sets_gie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !(irq_req_o && irq_ack_i)) |=> gie_q);

  p_grp0_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && grp_flag_q[0] && grp_en_q[0]) |-> (irq_vec_o == VEC_BASE));
endmodule

bind irq_group_ctrl irq_group_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_tb_i     (evt_tb_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .irq_req_o    (irq_req_o),
  .irq_vec_o    (irq_vec_o),
  .irq_ack_i    (irq_ack_i),
  .stack_full_i (stack_full_i),
  .reti_i       (reti_i),
  .gie_q        (gie),
  .src_flag_q   (src_flag),
  .grp_flag_q   (grp_flag),
  .grp_en_q     (grp_en)
);

// File: tb/test_irq_group_ctrl.sv
module test_irq_group_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] evt = '0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_req_o;
  logic [7:0] irq_vec_o;
  logic       irq_ack_i = 1'b0;
  logic       stack_full_i = 1'b0;
  logic       reti_i = 1'b0;

  int n_run = 0, n_fail = 0, n_push = 0, n_pop = 0;
  bit done = 1'b0;

  typedef struct {
    bit         is_irq;
    logic [8:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #2 clk_i = ~clk_i;

  irq_group_ctrl i_irq_group_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .evt_ser_xfer_i(evt[0]), .evt_ser_match_i(evt[1]),
    .evt_cnv_a_i(evt[2]), .evt_cnv_b_i(evt[3]),
    .evt_rtc_i(evt[4]), .evt_tb_i(evt[5]),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o),
    .irq_ack_i(irq_ack_i), .stack_full_i(stack_full_i), .reti_i(reti_i)
  );

  // monitor: samples 1 ns after the driver queues an item
  initial begin
    forever begin
      wait (n_push != n_pop);
      #1;
      begin
        item_t it;
        logic [8:0] act;
        it = sb_q.pop_front();
        n_run++;
        if (it.is_irq) begin
          act = {irq_req_o, irq_vec_o};
          if ((it.exp[8] && act != it.exp) || (!it.exp[8] && act[8])) begin
            n_fail++;
            $display("FAIL %s irq: actual %h expected %h", it.req, act, it.exp);
          end
        end else begin
          act = {1'b0, reg_rdata_o};
          if (act != it.exp) begin
            n_fail++;
            $display("FAIL %s rdata: actual %h expected %h", it.req, act, it.exp);
          end
        end
        n_pop++;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk_i);
    evt = m;
    @(negedge clk_i);
    evt = '0;
  endtask

  task automatic ack();
    @(negedge clk_i);
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
  endtask

  task automatic reti();
    @(negedge clk_i);
    reti_i = 1'b1;
    @(negedge clk_i);
    reti_i = 1'b0;
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [7:0] e, input string r);
    item_t it;
    reg_addr_i = a;
    it.is_irq = 1'b0; it.exp = {1'b0, e}; it.req = r;
    sb_q.push_back(it);
    n_push++;
    wait (n_pop == n_push);
  endtask

  task automatic chk_irq(input logic rq, input logic [7:0] v, input string r);
    item_t it;
    it.is_irq = 1'b1; it.exp = {rq, v}; it.req = r;
    sb_q.push_back(it);
    n_push++;
    wait (n_pop == n_push);
  endtask

  task automatic clr_flags();
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk_rd(2'd0, 8'h00, "R1");
    chk_rd(2'd1, 8'h00, "R1");
    chk_rd(2'd2, 8'h00, "R1");
    chk_irq(1'b0, 8'h00, "R1");

    // R2 / R10: flags set with sources disabled, no group flag
    pulse(6'h01); idle(1); chk_rd(2'd2, 8'h01, "R2 ser xfer");
    clr_flags();    chk_rd(2'd2, 8'h00, "R9 sw clear");
    pulse(6'h02); idle(1); chk_rd(2'd2, 8'h01, "R2 ser match");
    clr_flags();
    pulse(6'h04); idle(1); chk_rd(2'd2, 8'h02, "R2 cnv a");
    clr_flags();
    pulse(6'h08); idle(1); chk_rd(2'd2, 8'h02, "R2 cnv b");
    clr_flags();
    pulse(6'h10); pulse(6'h20); idle(1); chk_rd(2'd2, 8'h0C, "R2 rtc+tb");
    clr_flags();

    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h07);
    chk_rd(2'd0, 8'h07, "R4 ctrl");

    // R3 / R4: rtc -> group 1
    pulse(6'h10); idle(1);
    chk_rd(2'd2, 8'h24, "R3");
    chk_irq(1'b1, 8'h18, "R4 grp1");
    @(negedge clk_i); stack_full_i = 1'b1;
    chk_irq(1'b0, 8'h00, "R5");
    @(negedge clk_i); stack_full_i = 1'b0;
    chk_irq(1'b1, 8'h18, "R5 release");

    // R6 ack
    ack();
    chk_rd(2'd2, 8'h04, "R6 flags after ack");
    chk_rd(2'd0, 8'h06, "R6 gie clear");
    chk_irq(1'b0, 8'h00, "R6 no req");
    clr_flags();
    chk_rd(2'd2, 8'h00, "R6 sw clear");
    reti();
    chk_rd(2'd0, 8'h07, "R8 reti");

    // R7 priority
    pulse(6'h11); idle(1);
    chk_irq(1'b1, 8'h14, "R7 grp0 first");
    ack();
    chk_rd(2'd2, 8'h25, "R7 grp1 pending");
    wr(2'd2, 8'h24); wr(2'd2, 8'h24);
    chk_rd(2'd2, 8'h24, "R7 ser cleared");
    reti();
    chk_irq(1'b1, 8'h18, "R7 grp1 served");
    ack();
    clr_flags();
    reti();
    chk_irq(1'b0, 8'h00, "R8 idle");

    // R9 event beats same-cycle clear
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 8'h00; evt = 6'h20;
    @(negedge clk_i);
    reg_we_i = 1'b0; evt = '0;
    chk_rd(2'd2, 8'h08, "R9");
    idle(1);
    chk_irq(1'b1, 8'h18, "R9 req");
    ack();
    clr_flags();

    // R3 / R4: group enable off
    wr(2'd0, 8'h03);
    pulse(6'h10); idle(1);
    chk_rd(2'd2, 8'h24, "R3 grp en off");
    chk_irq(1'b0, 8'h00, "R4 grp en off");
    wr(2'd0, 8'h07);
    chk_irq(1'b1, 8'h18, "R4 grp en on");
    ack();
    clr_flags();
    reti();

    // R10 disabled source
    wr(2'd1, 8'h0E);
    pulse(6'h01); idle(1);
    chk_rd(2'd2, 8'h01, "R10");
    chk_irq(1'b0, 8'h00, "R10 no req");

    // R6 ack without request
    ack();
    chk_rd(2'd0, 8'h07, "R6 stray ack");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule